// File: doc/BRIEF.md
# Phase-Error Loop Filter with Holdover

This block is the digital heart of a mostly-digital phase-locked loop. A phase/frequency comparator outside the block compares a reference against the divided-down oscillator feedback and produces two level signals: one that leads when the feedback is late and one that leads when it is early. The comparator gives no numbers, only high and low levels. The block therefore measures each comparison window by counting fast-clock cycles. Cycles where only the "late" signal is high count up, and cycles where only the "early" signal is high count down. The signed total becomes the phase error for that reference period. The count clock is meant to run many times faster than the comparison rate, for example about a hundred cycles per reference period.

Each error sample goes through a proportional-plus-integral filter. Both gains are arithmetic right shifts, so the filter needs no multiplier. The filter output sets a 12-bit unsigned code for an external DAC that steers a crystal oscillator. The reference arrives in bursts with known timing. An external controller raises a hold input before a burst ends. While hold is high, both the control word and the integrator stay frozen at their last values. When hold drops, tracking continues from the frozen state with no jump.

Top module: `phase_loop_ctrl`

## Requirements
- R1: While reset is asserted and after its release, until the first filter update, the control word `ctrl_o` is mid-scale, 2048.
- R2: In a comparison window, a cycle with only `up_i` high adds 1 to the error and a cycle with only `dn_i` high subtracts 1. A cycle with both high leaves the error unchanged.
- R3: A window closes when the OR of both (synchronised) inputs falls. The error count is then latched and the counter restarts from zero, so no count carries into the next window.
- R4: The window count saturates at +2047 and at -2048 instead of wrapping.
- R5: The proportional term is the error arithmetically shifted right by `kp_shift_i`, which rounds toward minus infinity.
- R6: At each update, the integrator adds the error arithmetically shifted right by `ki_shift_i`. The integrator saturates at +8191 and -8192. It does not change between updates.
- R7: The new control word is 2048 + proportional term + updated integrator, clamped to the range 0..4095.
- R8: A new control word appears right after the fifth rising clock edge that follows the last edge at which `up_i` or `dn_i` was sampled high. At the fourth such edge, `ctrl_o` still shows its previous value.
- R9: If `hold_i` is high at the update, the window's error is discarded and `ctrl_o` and the integrator keep their values. After `hold_i` returns low, the next update starts from the frozen integrator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Comparator level: feedback lags the reference |
| dn_i | input | 1 | Comparator level: feedback leads the reference |
| hold_i | input | 1 | Freeze the filter state and the control word |
| kp_shift_i | input | 4 | Proportional gain as a right-shift amount |
| ki_shift_i | input | 4 | Integral gain as a right-shift amount |
| ctrl_o | output | 12 | Unsigned control code to the DAC |

## Verification
Each result in this block lands on one fixed cycle. The inputs pass two synchroniser stages. The window closes one edge after the synchronised OR falls. The filter registers one edge later and the output one edge after that, so the new code is due at the fifth edge after the last high input sample. The driver records the cycle count at the moment it drops the comparator inputs and queues the expected code with a due cycle five counts later. The monitor compares the output at exactly that cycle, and one cycle earlier it confirms the old code is still present. Every window, including those under hold, therefore gets one early-side and one on-time check.

// File: rtl/phase_loop_pkg.sv
package phase_loop_pkg;

    // Direction of one count-clock cycle, indexed as {up, dn}
    typedef enum logic [1:0] {
        DIR_IDLE = 2'b00,
        DIR_DN   = 2'b01,
        DIR_UP   = 2'b10,
        DIR_BOTH = 2'b11
    } step_dir_e;

endpackage

// File: rtl/pfd_sync.sv
module pfd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stg_d[g] = din;
        end else begin : g_chain
            assign stg_d[g] = stg_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/phase_err_counter.sv
module phase_err_counter
    import phase_loop_pkg::*;
#(
    parameter int ERR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    up_s,
    input  logic                    dn_s,
    output logic signed [ERR_W-1:0] cnt_o,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    err_vld_o
);

    localparam logic signed [ERR_W-1:0] CMAX = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic signed [ERR_W-1:0] CMIN = {1'b1, {(ERR_W-1){1'b0}}};

    typedef struct packed {
        logic signed [ERR_W-1:0] cnt;
        logic                    any_prev;
        logic signed [ERR_W-1:0] err;
        logic                    vld;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    step_dir_e dir;
    logic any_now;

    always_comb begin
        dir     = step_dir_e'({up_s, dn_s});
        any_now = up_s | dn_s;
        st_d    = st_q;
        st_d.vld = 1'b0;
        case (dir)
            DIR_UP:  if (st_q.cnt != CMAX) st_d.cnt = st_q.cnt + ERR_W'(1);
            DIR_DN:  if (st_q.cnt != CMIN) st_d.cnt = st_q.cnt - ERR_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        // window closes when the combined pulse falls
        if (st_q.any_prev && !any_now) begin
            st_d.err = st_q.cnt;
            st_d.vld = 1'b1;
            st_d.cnt = '0;
        end
        st_d.any_prev = any_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign err_o     = st_q.err;
    assign err_vld_o = st_q.vld;

endmodule

// File: rtl/pi_integrator.sv
module pi_integrator #(
    parameter int ERR_W = 12,
    parameter int INT_W = 14,
    parameter int SH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic                    err_vld_i,
    input  logic                    hold_i,
    input  logic [SH_W-1:0]         kp_sh_i,
    input  logic [SH_W-1:0]         ki_sh_i,
    output logic signed [ERR_W-1:0] prop_o,
    output logic signed [INT_W-1:0] integ_o,
    output logic                    upd_o
);

    localparam int AW = INT_W + 1;
    localparam logic signed [INT_W-1:0] IMAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic signed [INT_W-1:0] IMIN = {1'b1, {(INT_W-1){1'b0}}};

    typedef struct packed {
        logic signed [ERR_W-1:0] prop;
        logic signed [INT_W-1:0] integ;
        logic                    upd;
    } pi_st_t;

    pi_st_t st_d, st_q;
    logic signed [ERR_W-1:0] i_step;
    logic signed [AW-1:0]    i_sum;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        i_step   = err_i >>> ki_sh_i;
        i_sum    = AW'(st_q.integ) + AW'(i_step);
        if (err_vld_i && !hold_i) begin
            st_d.prop = err_i >>> kp_sh_i;
            if (i_sum[AW-1] != i_sum[AW-2]) begin
                st_d.integ = i_sum[AW-1] ? IMIN : IMAX;
            end else begin
                st_d.integ = i_sum[INT_W-1:0];
            end
            st_d.upd = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prop_o  = st_q.prop;
    assign integ_o = st_q.integ;
    assign upd_o   = st_q.upd;

endmodule

// File: rtl/dac_drive_stage.sv
module dac_drive_stage #(
    parameter int ERR_W = 12,
    parameter int INT_W = 14,
    parameter int DAC_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] prop_i,
    input  logic signed [INT_W-1:0] integ_i,
    input  logic                    upd_i,
    output logic [DAC_W-1:0]        ctrl_o
);

    localparam int SW = ((INT_W > DAC_W) ? INT_W : DAC_W) + 3;
    localparam logic signed [SW-1:0] MID_S  = SW'(2 ** (DAC_W - 1));
    localparam logic signed [SW-1:0] FULL_S = SW'((2 ** DAC_W) - 1);
    localparam logic [DAC_W-1:0]     MID_U  = DAC_W'(2 ** (DAC_W - 1));

    typedef struct packed {
        logic [DAC_W-1:0] ctrl;
    } dac_st_t;

    dac_st_t st_d, st_q;
    logic signed [SW-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = MID_S + SW'(prop_i) + SW'(integ_i);
        if (upd_i) begin
            if (sum < 0)           st_d.ctrl = '0;
            else if (sum > FULL_S) st_d.ctrl = '1;
            else                   st_d.ctrl = sum[DAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ctrl <= MID_U;
        else        st_q      <= st_d;
    end

    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/phase_loop_ctrl.sv
module phase_loop_ctrl #(
    parameter int ERR_W       = 12,
    parameter int INT_W       = 14,
    parameter int DAC_W       = 12,
    parameter int SH_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             hold_i,
    input  logic [SH_W-1:0]  kp_shift_i,
    input  logic [SH_W-1:0]  ki_shift_i,
    output logic [DAC_W-1:0] ctrl_o
);

    logic [1:0]              pfd_s;
    logic                    up_s;
    logic                    dn_s;
    logic signed [ERR_W-1:0] win_cnt;
    logic signed [ERR_W-1:0] err;
    logic                    err_vld;
    logic signed [ERR_W-1:0] prop;
    logic signed [INT_W-1:0] integ;
    logic                    upd;

    pfd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({up_i, dn_i}), .dout(pfd_s)
    );
    assign up_s = pfd_s[1];
    assign dn_s = pfd_s[0];

    phase_err_counter #(.ERR_W(ERR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .up_s(up_s), .dn_s(dn_s),
        .cnt_o(win_cnt), .err_o(err), .err_vld_o(err_vld)
    );

    pi_integrator #(.ERR_W(ERR_W), .INT_W(INT_W), .SH_W(SH_W)) u_pi (
        .clk(clk), .rst_n(rst_n), .err_i(err), .err_vld_i(err_vld),
        .hold_i(hold_i), .kp_sh_i(kp_shift_i), .ki_sh_i(ki_shift_i),
        .prop_o(prop), .integ_o(integ), .upd_o(upd)
    );

    dac_drive_stage #(.ERR_W(ERR_W), .INT_W(INT_W), .DAC_W(DAC_W)) u_dac (
        .clk(clk), .rst_n(rst_n), .prop_i(prop), .integ_i(integ),
        .upd_i(upd), .ctrl_o(ctrl_o)
    );

endmodule

// File: rtl/phase_loop_chk.sv
module phase_loop_chk #(
    parameter int ERR_W = 12,
    parameter int INT_W = 14,
    parameter int DAC_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    hold_i,
    input logic [DAC_W-1:0]        ctrl_o,
    input logic                    up_s,
    input logic                    dn_s,
    input logic signed [ERR_W-1:0] win_cnt,
    input logic                    err_vld,
    input logic signed [INT_W-1:0] integ
);

    localparam logic signed [ERR_W-1:0] CMAX = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic [DAC_W-1:0]        MID  = DAC_W'(2 ** (DAC_W - 1));

    // R1
    reset_mid_chk: assert property (@(posedge clk) !rst_n |-> ctrl_o == MID);

    // R2
    both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_s && dn_s) |=> $stable(win_cnt));

    // R3
    close_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld |=> !err_vld);

    // R4
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_s && !dn_s && win_cnt == CMAX) |=> win_cnt == CMAX);

    // R6
    integ_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> $stable(integ));

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && $past(hold_i)) |=> $stable(ctrl_o));

endmodule

bind phase_loop_ctrl phase_loop_chk #(.ERR_W(ERR_W), .INT_W(INT_W), .DAC_W(DAC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .ctrl_o(ctrl_o),
    .up_s(up_s), .dn_s(dn_s), .win_cnt(win_cnt), .err_vld(err_vld),
    .integ(integ)
);

// File: tb/phase_loop_ctrl_tb_top.sv
module phase_loop_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        up_i = 1'b0;
    logic        dn_i = 1'b0;
    logic        hold_i = 1'b0;
    logic [3:0]  kp_shift_i = 4'd0;
    logic [3:0]  ki_shift_i = 4'd0;
    logic [11:0] ctrl_o;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int m_integ = 0;
    int m_ctrl  = 2048;

    // scoreboard queues
    int    exp_q[$];
    int    prev_q[$];
    int    due_q[$];
    string tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phase_loop_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i), .hold_i(hold_i),
        .kp_shift_i(kp_shift_i), .ki_shift_i(ki_shift_i), .ctrl_o(ctrl_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // Driver: one comparison window, then queue the expected code
    task automatic run_window(input bit lead_up, input int lead, input int overlap,
                              input string tag);
        int err;
        int p;
        int inew;
        int prev;
        @(negedge clk);
        if (lead_up) up_i = 1'b1; else dn_i = 1'b1;
        repeat (lead) @(negedge clk);
        up_i = 1'b1;
        dn_i = 1'b1;
        repeat (overlap) @(negedge clk);
        up_i = 1'b0;
        dn_i = 1'b0;
        err  = clampi(lead_up ? lead : -lead, -2048, 2047);
        prev = m_ctrl;
        if (!hold_i) begin
            p       = err >>> kp_shift_i;
            inew    = clampi(m_integ + (err >>> ki_shift_i), -8192, 8191);
            m_integ = inew;
            m_ctrl  = clampi(2048 + p + inew, 0, 4095);
        end
        exp_q.push_back(m_ctrl);
        prev_q.push_back(prev);
        due_q.push_back(cyc + 5);
        tag_q.push_back(tag);
        repeat (8) @(negedge clk);
    endtask

    // Monitor: R8 timing, old value one cycle early, new value on time
    always @(negedge clk) begin
        if (due_q.size() > 0) begin
            if (cyc == due_q[0] - 1) begin
                check(ctrl_o == 12'(prev_q[0]), {"R8 early ", tag_q[0]}, ctrl_o, prev_q[0]);
            end else if (cyc == due_q[0]) begin
                check(ctrl_o == 12'(exp_q[0]), tag_q[0], ctrl_o, exp_q[0]);
                void'(exp_q.pop_front());
                void'(prev_q.pop_front());
                void'(due_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #3 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(ctrl_o == 12'd2048, "R1 in reset", ctrl_o, 2048);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(ctrl_o == 12'd2048, "R1 after reset", ctrl_o, 2048);

        // basic up-only and down-only windows
        kp_shift_i = 4'd2; ki_shift_i = 4'd3;
        run_window(1'b1, 10, 0, "R2 R5 R6 R7 up-only");
        kp_shift_i = 4'd1; ki_shift_i = 4'd2;
        run_window(1'b0, 20, 0, "R2 R7 down-only");
        // floor rounding of small negative error
        kp_shift_i = 4'd4; ki_shift_i = 4'd2;
        run_window(1'b0, 3, 0, "R5 R6 negative shift floor");
        // overlapping pulses: both-high cycles add nothing
        kp_shift_i = 4'd0; ki_shift_i = 4'd1;
        run_window(1'b1, 6, 15, "R2 overlap up-lead");
        run_window(1'b0, 9, 12, "R2 overlap dn-lead");
        run_window(1'b1, 0, 14, "R2 both-together");
        // consecutive windows start from zero
        run_window(1'b1, 7, 2, "R3 restart 1");
        run_window(1'b1, 7, 2, "R3 restart 2");

        // hold: freeze, then resume from frozen integrator
        hold_i = 1'b1;
        repeat (2) @(negedge clk);
        run_window(1'b1, 40, 3, "R9 held up");
        run_window(1'b0, 60, 3, "R9 held down");
        hold_i = 1'b0;
        repeat (2) @(negedge clk);
        run_window(1'b1, 5, 3, "R9 resume");

        // window count saturation both ways
        kp_shift_i = 4'd4; ki_shift_i = 4'd15;
        run_window(1'b1, 2300, 2, "R4 count sat high");
        run_window(1'b0, 2300, 2, "R4 count sat low");

        // integrator saturation and output clamping
        kp_shift_i = 4'd15; ki_shift_i = 4'd0;
        for (int k = 0; k < 5; k++) run_window(1'b1, 2300, 1, "R6 R7 integ up");
        for (int k = 0; k < 9; k++) run_window(1'b0, 2300, 1, "R6 R7 integ down");

        repeat (10) @(negedge clk);
        check(due_q.size() == 0, "R8 queue drained", due_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule